// File: doc/BRIEF.md
# Qualified Configuration Register Bank

This block holds the configuration of a small waveform generator in seven 8-bit registers that can be written but not read back. A controller places a register index on a 3-bit address bus and a byte on an 8-bit data bus, then pulls an active-low write strobe. The block accepts the write only after the strobe has stayed low, with address and data unchanged, for three clocks in a row. All bus pins pass through a two-stage synchronizer first, so the controller may run from an unrelated clock.

Writes are accepted only while the generator is halted, which means the run input is low. A write made while the generator runs is dropped. The seven registers are joined into one 56-bit control word, with register 0 in the top byte. The block decodes the mode bits and the prescaler from this word, and it also provides the DC level used in constant mode: the amplitude register plus the signed offset register, wrapping modulo 256.

Top module: `fg_cfg_bank`

## Requirements
- R1: After reset the control word is 0x49_05_00_00_00_32_00, so const_mode=0, sine_sel=1, prescale=9 and dc_level=0x32.
- R2: A write to address i (0..6) replaces bits [55-8i : 48-8i] of ctrl_word and leaves the other registers unchanged.
- R3: A write happens only if the strobe is sampled low on at least three consecutive clocks. A strobe that is low for one or two clocks writes nothing. A write shows on ctrl_word within five clocks after the first low sample.
- R4: If address or data change while the strobe is low and no write has happened yet, the three-clock count starts again from the change.
- R5: A strobe low period makes at most one write. Changes to address or data after that write, while the strobe stays low, have no effect.
- R6: A write whose third qualifying clock arrives while the synchronized run input is high is discarded.
- R7: A write to address 7 changes no register.
- R8: const_mode is ctrl_word bit 55, sine_sel is bit 54 (1 selects sine), and prescale is bits 53:48.
- R9: dc_level equals register 5 plus register 6 modulo 256, with register 6 read as a two's-complement offset.
- R10: An active-low rst_n returns every register to its default at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | 1 = generator runs, 0 = halted (programming allowed) |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register index |
| wdata | input | 8 | Write data |
| ctrl_word | output | 56 | Concatenated registers, register 0 in the top byte |
| const_mode | output | 1 | Constant (DC) mode flag |
| sine_sel | output | 1 | Modulation select, 1 = sine |
| prescale | output | 6 | Timer prescaler |
| dc_level | output | 8 | Amplitude plus offset, wrapped |

## Verification
The run input and the write qualifier can both act on the same clock: the strobe's third qualifying sample may meet the first high sample of run_en. The bench holds a strobe low for four clocks and raises run_en after either two or three clocks of strobe. Because both signals pass through synchronizers of the same depth, the first case must drop the write and the second must accept it. The bench judges each case from the register's value on ctrl_word once the strobe has been released.

// File: rtl/fg_cfg_bank.sv
module fg_cfg_bank #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int NREG = 7,
  parameter int QUAL = 3,
  parameter int SYNC = 2,
  parameter logic [NREG*DW-1:0] RST_WORD = 56'h49_05_00_00_00_32_00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               wr_n,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] ctrl_word,
  output logic               const_mode,
  output logic               sine_sel,
  output logic [DW-3:0]      prescale,
  output logic [DW-1:0]      dc_level
);

  localparam int CW      = $clog2(QUAL + 1);
  localparam int WW      = NREG * DW;
  localparam int AMP_IDX = 5;
  localparam int OFF_IDX = 6;
  localparam int AMP_LSB = (NREG - 1 - AMP_IDX) * DW;
  localparam int OFF_LSB = (NREG - 1 - OFF_IDX) * DW;

  logic [SYNC-1:0]         wr_sh, en_sh;
  logic [SYNC-1:0][AW-1:0] ad_sh;
  logic [SYNC-1:0][DW-1:0] dt_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sh <= '1;
      en_sh <= '1;
      ad_sh <= '0;
      dt_sh <= '0;
    end else begin
      wr_sh <= {wr_sh[SYNC-2:0], wr_n};
      en_sh <= {en_sh[SYNC-2:0], run_en};
      ad_sh <= {ad_sh[SYNC-2:0], addr};
      dt_sh <= {dt_sh[SYNC-2:0], wdata};
    end
  end

  logic          wr_s, en_s;
  logic [AW-1:0] ad_s, ad_p;
  logic [DW-1:0] dt_s, dt_p;
  logic [CW-1:0] cnt;
  logic          stable, commit, go;
  logic [NREG-1:0] we;

  assign wr_s   = wr_sh[SYNC-1];
  assign en_s   = en_sh[SYNC-1];
  assign ad_s   = ad_sh[SYNC-1];
  assign dt_s   = dt_sh[SYNC-1];
  assign stable = (ad_s == ad_p) && (dt_s == dt_p);
  assign commit = !wr_s && stable && (cnt == CW'(QUAL - 1));
  assign go     = commit && !en_s && ({1'b0, ad_s} < (AW+1)'(NREG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ad_p <= '0;
      dt_p <= '0;
    end else begin
      ad_p <= ad_s;
      dt_p <= dt_s;
      if (wr_s)                         cnt <= '0;
      else if (cnt == CW'(QUAL))        cnt <= cnt;
      else if (cnt == '0 || !stable)    cnt <= CW'(1);
      else                              cnt <= cnt + CW'(1);
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] r;
    assign we[g] = go && (ad_s == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     r <= RST_WORD[(NREG-1-g)*DW +: DW];
      else if (we[g]) r <= dt_s;
    end
    assign ctrl_word[(NREG-1-g)*DW +: DW] = r;
  end

  assign const_mode = ctrl_word[WW-1];
  assign sine_sel   = ctrl_word[WW-2];
  assign prescale   = ctrl_word[WW-3 -: DW-2];
  assign dc_level   = ctrl_word[AMP_LSB +: DW] + ctrl_word[OFF_LSB +: DW];

  a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));

  a_r3_three_lows: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(!wr_s) && $past(!wr_s, 2)));

  a_r5_one_per_low: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  a_r6_halted_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word) |-> $past(!en_s));

  a_r7_addr_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && ({1'b0, ad_s} >= (AW+1)'(NREG))) |=> $stable(ctrl_word));

endmodule

// File: tb/fg_cfg_bank_tb.sv
`timescale 1ns/1ps
module fg_cfg_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        wr_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [55:0] ctrl_word;
  logic        const_mode, sine_sel;
  logic [5:0]  prescale;
  logic [7:0]  dc_level;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [55:0] model;

  always #2.5 clk = ~clk;

  fg_cfg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .ctrl_word(ctrl_word), .const_mode(const_mode),
    .sine_sel(sine_sel), .prescale(prescale), .dc_level(dc_level)
  );

  // {en[15], low[14:12], addr[11:9], unused[8], data[7:0]}
  localparam int NV = 11;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 3'd3, 3'd1, 1'b0, 8'hA7},
    {1'b0, 3'd2, 3'd2, 1'b0, 8'h11},
    {1'b0, 3'd4, 3'd2, 1'b0, 8'h11},
    {1'b1, 3'd4, 3'd3, 1'b0, 8'h5C},
    {1'b0, 3'd3, 3'd7, 1'b0, 8'hFF},
    {1'b0, 3'd5, 3'd0, 1'b0, 8'hC3},
    {1'b0, 3'd3, 3'd5, 1'b0, 8'hF0},
    {1'b0, 3'd3, 3'd6, 1'b0, 8'h20},
    {1'b0, 3'd1, 3'd4, 1'b0, 8'h77},
    {1'b0, 3'd3, 3'd4, 1'b0, 8'h77},
    {1'b0, 3'd6, 3'd3, 1'b0, 8'h9E}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [7:0] d);
    model[(6-a)*8 +: 8] = d;
  endtask

  task automatic strobe(input logic [2:0] a, input logic [7:0] d, input int low);
    @(negedge clk);
    wr_n = 1'b0; addr = a; wdata = d;
    repeat (low) @(negedge clk);
    wr_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      summary();
    end
  end

  initial begin
    model = 56'h49_05_00_00_00_32_00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(ctrl_word == model, "R1 word", ctrl_word, model);
    chk(const_mode == 1'b0 && sine_sel == 1'b1 && prescale == 6'd9, "R1 fields",
        {const_mode, sine_sel, prescale}, {1'b0, 1'b1, 6'd9});
    chk(dc_level == 8'h32, "R1 dc", dc_level, 8'h32);

    // R2 R3 R6 R7 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0] exp_dc;
      run_en = VEC[i][15];
      repeat (3) @(negedge clk);
      strobe(VEC[i][11:9], VEC[i][7:0], int'(VEC[i][14:12]));
      if (VEC[i][14:12] >= 3 && !VEC[i][15] && VEC[i][11:9] < 7)
        put(int'(VEC[i][11:9]), VEC[i][7:0]);
      chk(ctrl_word == model, $sformatf("R2/R3/R6/R7 vec%0d", i), ctrl_word, model);
      exp_dc = model[15:8] + model[7:0];
      chk(dc_level == exp_dc, $sformatf("R9 vec%0d", i), dc_level, exp_dc);
      run_en = 1'b0;
    end
    repeat (3) @(negedge clk);

    // R8 field decode after CR0 = 0xC3
    chk(const_mode == 1'b1 && sine_sel == 1'b1 && prescale == 6'd3, "R8 fields",
        {const_mode, sine_sel, prescale}, {1'b1, 1'b1, 6'd3});
    // R9 wrap: 0xF0 + 0x20 = 0x10
    chk(dc_level == 8'h10, "R9 wrap", dc_level, 8'h10);

    // R4 data change restarts count: 2 + 2 clocks -> no write
    @(negedge clk);
    wr_n = 1'b0; addr = 3'd3; wdata = 8'h12;
    repeat (2) @(negedge clk);
    wdata = 8'h34;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(ctrl_word == model, "R4 restart no write", ctrl_word, model);
    // R4 change then held 3 clocks -> writes new value
    @(negedge clk);
    wr_n = 1'b0; addr = 3'd3; wdata = 8'h12;
    repeat (2) @(negedge clk);
    wdata = 8'h34;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (8) @(negedge clk);
    put(3, 8'h34);
    chk(ctrl_word == model, "R4 restart then write", ctrl_word, model);

    // R5 one write per low period
    @(negedge clk);
    wr_n = 1'b0; addr = 3'd4; wdata = 8'hAA;
    repeat (3) @(negedge clk);
    wdata = 8'hBB; addr = 3'd2;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (8) @(negedge clk);
    put(4, 8'hAA);
    chk(ctrl_word == model, "R5 single write", ctrl_word, model);

    // R6 run_en rising two clocks into strobe -> discarded
    @(negedge clk);
    wr_n = 1'b0; addr = 3'd2; wdata = 8'h66;
    repeat (2) @(negedge clk);
    run_en = 1'b1;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(ctrl_word == model, "R6 race discarded", ctrl_word, model);
    run_en = 1'b0;
    repeat (3) @(negedge clk);
    // R6 run_en rising three clocks into strobe -> accepted
    @(negedge clk);
    wr_n = 1'b0; addr = 3'd2; wdata = 8'h67;
    repeat (3) @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
    wr_n = 1'b1;
    repeat (8) @(negedge clk);
    put(2, 8'h67);
    chk(ctrl_word == model, "R6 race accepted", ctrl_word, model);
    run_en = 1'b0;
    repeat (3) @(negedge clk);

    // R10 asynchronous reset between edges
    #1;
    rst_n = 1'b0;
    #0.5;
    model = 56'h49_05_00_00_00_32_00;
    chk(ctrl_word == model, "R10 async reset", ctrl_word, model);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dc_level == 8'h32, "R10 dc after reset", dc_level, 8'h32);

    finished = 1;
    summary();
  end

endmodule